// File: doc/BRIEF.md
# Load-Multiple-Word Sequencer

This block carries out a load-multiple-word operation for a 64-bit integer core. When started, it takes a first target register number, a base register number with that register's value, and a signed displacement. It then reads consecutive 32-bit words from memory and writes each one, zero-extended, into the first target register and every higher-numbered register through the last register of the file. The start address is the displacement plus the base value. A base register number of zero contributes zero in place of a register value. The address grows by four bytes per word.

The block checks the request before it touches memory. If the core runs little-endian, it pulses an alignment-error flag. Otherwise, if the base register is zero or lies inside the range about to be overwritten, it pulses an invalid-form flag. In both cases it issues no memory read and no register write. Memory reads use a request pulse, and the read stays pending until an acknowledge arrives with the data, however many cycles that takes. A one-cycle done pulse ends a good sequence.

Top module: `lmw_seq`

## Requirements
- R1: A valid request with first register F performs exactly 32-F register writes and 32-F memory read requests.
- R2: The writes go to registers F, F+1, ... 31 in ascending order. Read k (counting from 0) uses address base+sext(disp)+4k. The base term is 0 when the base register number is 0.
- R3: Each register write carries the memory word in bits 31:0, and bits 63:32 are zero.
- R4: A base register number of 0 pulses invalid_o for one cycle, in the cycle after start. No read or write follows, and busy_o stays low.
- R5: A nonzero base register number that is greater than or equal to F pulses invalid_o in the same way, with no read or write.
- R6: When little_endian_i is 1 at start, align_o pulses for one cycle and invalid_o stays low, even if the form is also invalid. No read or write follows.
- R7: done_o is high for exactly one cycle, in the cycle after the write to register 31. busy_o is low in the cycle after that.
- R8: A start pulse while busy_o is high is ignored. The sequence in progress continues unchanged, and no error flag pulses.
- R9: Each mem_req_o is a one-cycle pulse. The next request or register write waits for mem_ack_i, whatever the acknowledge latency.
- R10: After reset, busy_o, done_o, mem_req_o, rf_we_o, invalid_o and align_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle |
| first_reg_i | input | 5 | First target register number F |
| base_reg_i | input | 5 | Base register number (0 means no base) |
| base_val_i | input | 64 | Value of the base register |
| disp_i | input | 16 | Signed displacement |
| little_endian_i | input | 1 | Core byte-order mode, 1 = little-endian |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| invalid_o | output | 1 | One-cycle invalid-form pulse |
| align_o | output | 1 | One-cycle alignment-error pulse |
| mem_req_o | output | 1 | Memory word read request pulse |
| mem_addr_o | output | 64 | Byte address of the requested word |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data word |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write index |
| rf_wdata_o | output | 64 | Register file write data |

## Verification
The hardest cases to reach are the ones where the sequence runs next to other traffic. One is a start pulse, including one that would raise an error, arriving in the middle of a sequence. The other is the window between a read request and its acknowledge. To reach them, the bench memory answers with a latency that each test chooses. It then injects a second start, with different fields and little-endian set, while a long sequence waits on a slow acknowledge. It checks that the writes and addresses still match the first request and that no error flag pulses. The error paths are also driven with a base register at exactly F, at 31, and at 0. These cases separate an off-by-one range check from a correct one.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_ISSUE = 3'd1,
      S_WAIT  = 3'd2,
      S_WRITE = 3'd3,
      S_DONE  = 3'd4
   } lmw_state_e;
endpackage

// File: rtl/lmw_check.sv
module lmw_check #(
   parameter int RIDX = 5
) (
   input  logic [RIDX-1:0] first_reg_i,
   input  logic [RIDX-1:0] base_reg_i,
   input  logic            little_endian_i,
   output logic            rej_form_o,
   output logic            rej_align_o
);
   // byte-order check takes priority over the form check
   always_comb begin
      rej_align_o = little_endian_i;
      rej_form_o  = !little_endian_i &&
                    ((base_reg_i == '0) || (base_reg_i >= first_reg_i));
   end
endmodule

// File: rtl/lmw_datapath.sv
module lmw_datapath #(
   parameter int XLEN  = 64,
   parameter int WORD  = 32,
   parameter int NREG  = 32,
   parameter int DISPW = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic                     adv_i,
   input  logic                     cap_i,
   input  logic [$clog2(NREG)-1:0]  first_reg_i,
   input  logic [$clog2(NREG)-1:0]  base_reg_i,
   input  logic [XLEN-1:0]          base_val_i,
   input  logic [DISPW-1:0]         disp_i,
   input  logic [WORD-1:0]          rdata_i,
   output logic [XLEN-1:0]          addr_o,
   output logic [$clog2(NREG)-1:0]  idx_o,
   output logic                     last_o,
   output logic [XLEN-1:0]          wdata_o
);
   localparam int RIDX = $clog2(NREG);
   localparam int STEP = WORD / 8;

   logic [XLEN-1:0] base_eff;
   logic [XLEN-1:0] disp_ext;
   logic [WORD-1:0] word_q;

   assign base_eff = (base_reg_i == '0) ? '0 : base_val_i;
   assign disp_ext = {{(XLEN-DISPW){disp_i[DISPW-1]}}, disp_i};
   assign last_o   = (idx_o == RIDX'(NREG-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         idx_o  <= '0;
         word_q <= '0;
      end else begin
         if (load_i) begin
            addr_o <= base_eff + disp_ext;
            idx_o  <= first_reg_i;
         end else if (adv_i) begin
            addr_o <= addr_o + XLEN'(STEP);
            idx_o  <= idx_o + 1'b1;
         end
         if (cap_i) word_q <= rdata_i;
      end
   end

   generate
      if (XLEN == WORD) begin : g_full
         assign wdata_o = word_q;
      end else begin : g_pad
         assign wdata_o = {{(XLEN-WORD){1'b0}}, word_q};
      end
   endgenerate

   // R2: after a non-final write, the next address is one word further
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !last_o) |=> (addr_o == $past(addr_o) + XLEN'(STEP)));
endmodule

// File: rtl/lmw_fsm.sv
module lmw_fsm
   import lmw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rej_form_i,
   input  logic rej_align_i,
   input  logic ack_i,
   input  logic last_i,
   output logic load_o,
   output logic adv_o,
   output logic cap_o,
   output logic req_o,
   output logic we_o,
   output logic done_o,
   output logic busy_o,
   output logic invalid_o,
   output logic align_o
);
   lmw_state_e state_q, state_d;
   logic       accept;

   assign accept = start_i && (state_q == S_IDLE);
   assign load_o = accept && !rej_form_i && !rej_align_i;
   assign req_o  = (state_q == S_ISSUE);
   assign cap_o  = (state_q == S_WAIT) && ack_i;
   assign we_o   = (state_q == S_WRITE);
   assign adv_o  = we_o;
   assign done_o = (state_q == S_DONE);
   assign busy_o = (state_q != S_IDLE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_IDLE:  if (load_o) state_d = S_ISSUE;
         S_ISSUE: state_d = S_WAIT;
         S_WAIT:  if (ack_i) state_d = S_WRITE;
         S_WRITE: state_d = last_i ? S_DONE : S_ISSUE;
         S_DONE:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         invalid_o <= 1'b0;
         align_o   <= 1'b0;
      end else begin
         state_q   <= state_d;
         invalid_o <= accept && rej_form_i;
         align_o   <= accept && rej_align_i;
      end
   end

   // R9: a request lasts one cycle
   p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |=> !req_o);
   // R7: done only follows the last write
   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(we_o && last_i));
   // R7: done is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);
   // R4: a rejected request never launches a sequence
   p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (invalid_o || align_o) |-> !busy_o);
endmodule

// File: rtl/lmw_seq.sv
module lmw_seq #(
   parameter int XLEN  = 64,
   parameter int WORD  = 32,
   parameter int NREG  = 32,
   parameter int DISPW = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [$clog2(NREG)-1:0] first_reg_i,
   input  logic [$clog2(NREG)-1:0] base_reg_i,
   input  logic [XLEN-1:0]         base_val_i,
   input  logic [DISPW-1:0]        disp_i,
   input  logic                    little_endian_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    invalid_o,
   output logic                    align_o,
   output logic                    mem_req_o,
   output logic [XLEN-1:0]         mem_addr_o,
   input  logic                    mem_ack_i,
   input  logic [WORD-1:0]         mem_rdata_i,
   output logic                    rf_we_o,
   output logic [$clog2(NREG)-1:0] rf_waddr_o,
   output logic [XLEN-1:0]         rf_wdata_o
);
   localparam int RIDX = $clog2(NREG);

   if (XLEN < WORD)         begin : g_bad_xlen  $error("XLEN below WORD");        end
   if (WORD % 8 != 0)       begin : g_bad_word  $error("WORD not byte multiple"); end
   if ((1 << RIDX) != NREG) begin : g_bad_nreg  $error("NREG not power of two");  end
   if (DISPW >= XLEN)       begin : g_bad_disp  $error("DISPW too wide");         end

   logic rej_form, rej_align, load, adv, cap, last;

   lmw_check #(.RIDX(RIDX)) u_check (
      .first_reg_i    (first_reg_i),
      .base_reg_i     (base_reg_i),
      .little_endian_i(little_endian_i),
      .rej_form_o     (rej_form),
      .rej_align_o    (rej_align)
   );

   lmw_datapath #(.XLEN(XLEN), .WORD(WORD), .NREG(NREG), .DISPW(DISPW)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .adv_i      (adv),
      .cap_i      (cap),
      .first_reg_i(first_reg_i),
      .base_reg_i (base_reg_i),
      .base_val_i (base_val_i),
      .disp_i     (disp_i),
      .rdata_i    (mem_rdata_i),
      .addr_o     (mem_addr_o),
      .idx_o      (rf_waddr_o),
      .last_o     (last),
      .wdata_o    (rf_wdata_o)
   );

   lmw_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .rej_form_i (rej_form),
      .rej_align_i(rej_align),
      .ack_i      (mem_ack_i),
      .last_i     (last),
      .load_o     (load),
      .adv_o      (adv),
      .cap_o      (cap),
      .req_o      (mem_req_o),
      .we_o       (rf_we_o),
      .done_o     (done_o),
      .busy_o     (busy_o),
      .invalid_o  (invalid_o),
      .align_o    (align_o)
   );

   // R3: upper half of every written register is clear
   if (XLEN > WORD) begin : g_zero_chk
      p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         rf_we_o |-> (rf_wdata_o[XLEN-1:WORD] == '0));
   end
   // R9: a write follows an acknowledge, never a bare request
   p_write_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> $past(mem_ack_i));
   // R6: the two error flags never pulse together
   p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(invalid_o && align_o));
endmodule

// File: tb/sim_lmw_seq.sv
module sim_lmw_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [4:0]  first_reg_i = '0;
   logic [4:0]  base_reg_i = '0;
   logic [63:0] base_val_i = '0;
   logic [15:0] disp_i = '0;
   logic        little_endian_i = 1'b0;
   logic        busy_o, done_o, invalid_o, align_o, mem_req_o, rf_we_o;
   logic [63:0] mem_addr_o, rf_wdata_o;
   logic        mem_ack_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic [4:0]  rf_waddr_o;

   int checks = 0, fails = 0;
   int lat = 1;
   int pend_cnt = 0;
   logic [63:0] pend_addr;
   int n_req = 0, n_wr = 0, n_done = 0, n_inv = 0, n_aln = 0;
   logic [63:0] req_addr [32];
   logic [4:0]  wr_idx [32];
   logic [63:0] wr_data [32];
   logic        prev_we31 = 1'b0;
   int          done_good = 0;
   int          cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   lmw_seq u0 (.*);

   function automatic logic [31:0] memword(input logic [63:0] a);
      return a[31:0] ^ 32'h5A3C_0F96;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model and monitor, all at the falling edge
   always @(negedge clk) begin
      cycles++;
      mem_ack_i = 1'b0;
      if (pend_cnt > 0) begin
         pend_cnt--;
         if (pend_cnt == 0) begin
            mem_ack_i   = 1'b1;
            mem_rdata_i = memword(pend_addr);
         end
      end
      if (mem_req_o) begin
         if (n_req < 32) req_addr[n_req] = mem_addr_o;
         n_req++;
         pend_addr = mem_addr_o;
         pend_cnt  = lat;
      end
      if (done_o) begin
         n_done++;
         if (prev_we31) done_good++;
      end
      if (invalid_o) n_inv++;
      if (align_o) n_aln++;
      prev_we31 = rf_we_o && (rf_waddr_o == 5'd31);
      if (rf_we_o) begin
         if (n_wr < 32) begin
            wr_idx[n_wr]  = rf_waddr_o;
            wr_data[n_wr] = rf_wdata_o;
         end
         n_wr++;
      end
      if (cycles > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic clear_counts();
      n_req = 0; n_wr = 0; n_done = 0; n_inv = 0; n_aln = 0; done_good = 0;
   endtask

   task automatic issue(input logic [4:0] f, input logic [4:0] b,
                        input logic [63:0] bv, input logic [15:0] d, input logic le);
      @(negedge clk);
      first_reg_i = f; base_reg_i = b; base_val_i = bv; disp_i = d;
      little_endian_i = le; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while ((busy_o || n_done == 0) && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R10 busy", busy_o, 0);
      check("R10 done", done_o, 0);
      check("R10 req", mem_req_o, 0);
      check("R10 we", rf_we_o, 0);
      check("R10 flags", {invalid_o, align_o}, 0);
   endtask

   task automatic t_run(input logic [4:0] f, input logic [4:0] b, input logic [63:0] bv,
                        input logic [15:0] d, input int l, input bit poke);
      logic [63:0] ea;
      int n;
      n = 32 - f;
      ea = bv + {{48{d[15]}}, d};
      lat = l;
      clear_counts();
      issue(f, b, bv, d, 1'b0);
      if (poke) begin
         repeat (5) @(negedge clk);
         // R8: second start while busy, with little-endian and different register
         issue(5'd30, 5'd2, 64'h1234, 16'h0040, 1'b1);
      end
      wait_idle();
      check("R1 writes", n_wr, n);
      check("R1 reads", n_req, n);
      check("R7 done count", n_done, 1);
      check("R7 done after reg31", done_good, 1);
      check("R7 idle after done", busy_o, 0);
      if (poke) check("R8 no flags", n_inv + n_aln, 0);
      for (int i = 0; i < n && i < 32; i++) begin
         check("R2 reg order", wr_idx[i], f + i);
         check("R2 address", req_addr[i], ea + 64'(4 * i));
         check("R3 data", wr_data[i], {32'h0, memword(ea + 64'(4 * i))});
      end
   endtask

   task automatic t_err(input string req, input logic [4:0] f, input logic [4:0] b,
                        input logic le, input bit exp_inv, input bit exp_aln);
      clear_counts();
      lat = 1;
      @(negedge clk);
      first_reg_i = f; base_reg_i = b; base_val_i = 64'h100; disp_i = 16'h8;
      little_endian_i = le; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check({req, " invalid pulse"}, invalid_o, exp_inv);
      check({req, " align pulse"}, align_o, exp_aln);
      repeat (6) @(negedge clk);
      check({req, " pulse count"}, n_inv + n_aln, 1);
      check({req, " no reads"}, n_req, 0);
      check({req, " no writes"}, n_wr, 0);
      check({req, " not busy"}, busy_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run(5'd28, 5'd3, 64'h0000_0000_0000_1000, 16'h0010, 1, 0);
      t_run(5'd31, 5'd7, 64'h0000_0000_8000_0000, 16'hFFF8, 3, 0);   // negative displacement
      t_run(5'd2, 5'd1, 64'h0000_00FF_FFFF_FFF0, 16'h0004, 1, 0);    // long run, carry past 32 bits
      t_run(5'd10, 5'd9, 64'h0000_0000_0002_0000, 16'h7FFC, 7, 1);   // slow memory plus busy start
      t_err("R4", 5'd20, 5'd0, 1'b0, 1, 0);
      t_err("R5 base=F", 5'd20, 5'd20, 1'b0, 1, 0);
      t_err("R5 base=31", 5'd20, 5'd31, 1'b0, 1, 0);
      t_err("R6", 5'd20, 5'd5, 1'b1, 0, 1);
      t_err("R6 priority", 5'd20, 5'd25, 1'b1, 0, 1);
      t_run(5'd20, 5'd19, 64'h40, 16'h0, 2, 0);                      // base just below F is valid
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule